// File: doc/BRIEF.md
# Dword Valid-Mask Packing Stage

This stage sits between user logic and a card-to-host DMA buffer. User logic writes 66-bit beats. Each beat carries two 32-bit dwords and a per-dword valid mask. The mask may take any value on any write cycle, including upper-only and lower-only patterns in the middle of a transfer. The stage compacts the valid dwords so that the stream it writes downstream has no holes. Every beat it emits is full (mask 2'b11), except the one partial beat that closes a transfer.

A one-dword holding register keeps a leftover dword until the next valid dword arrives to pair with it. A separate flush strobe, given on a cycle with no write, closes the transfer. If a dword is waiting, the flush pushes it out as a partial beat. The stage also tracks how many beats sit in the downstream buffer, using its own pushes and the reader's pops. From that count it raises a programmable-full flag that user logic uses as backpressure.

Top module: `dwpk_pack_stage`

## Requirements
- R1: After reset, `out_wr` and `prog_full` are low and no dword is held, so a flush with no write emits nothing.
- R2: Bit layout, for input and output alike: bits 63:32 hold the earlier dword, bits 31:0 the later one, bit 65 marks the upper dword valid and bit 64 marks the lower dword valid. With nothing held, a write with mask 2'b11 emits the same two dwords as a full beat, with `out_wr` high, in the cycle after the write.
- R3: With nothing held, a write with exactly one valid dword emits nothing and keeps that dword. The next write that carries a valid dword emits a full beat whose upper dword is the kept one and whose lower dword is the first new valid dword.
- R4: With a dword held, a write with mask 2'b11 emits {held, new upper} as a full beat and keeps the new lower dword.
- R5: A write with mask 2'b00 emits nothing and leaves the held dword unchanged.
- R6: A flush on a cycle with no write, while a dword is held, emits one beat with mask 2'b10. Its upper dword is the held one and its lower dword is zero. Afterwards nothing is held.
- R7: A flush has no effect when nothing is held, or when it coincides with a write. In that case the write is processed as if the flush were low.
- R8: Every emitted beat has mask 2'b11, except a flush beat, which has mask 2'b10. Mask 2'b00 is never emitted.
- R9: Occupancy counts emitted beats minus `fifo_rd` pops, and a pop at zero occupancy is ignored. `prog_full` is high exactly when occupancy exceeds THRESH (default 500 of 512). It follows the count one cycle after the beat appears on `out_wr`.
- R10: The sequence of emitted valid dwords, upper before lower within each beat, equals the sequence of valid input dwords, upper before lower within each beat, for any mask sequence. For example, inputs {D0,D1}, {D2,-}, {-,D3}, {D4,-} and then a flush yield D0, D1, D2, D3, D4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr | input | 1 | User write strobe |
| in_beat | input | 66 | User beat: mask in 65:64, dwords in 63:0 |
| flush | input | 1 | End-of-transfer strobe, acted on only without a write |
| out_wr | output | 1 | Write strobe to the downstream buffer |
| out_beat | output | 66 | Packed beat, same layout as `in_beat` |
| fifo_rd | input | 1 | Pop strobe from the downstream reader |
| prog_full | output | 1 | Occupancy above threshold |

## Verification
A packed beat appears on `out_wr` and `out_beat` in the cycle after the write or flush that completes it. The bench therefore drives each stimulus on a falling edge and samples the outputs on the next falling edge, one rising edge later. `prog_full` sits one register further down, since the occupancy counter updates on the edge after `out_wr` is seen high. The fill checks therefore insert one idle cycle after the last push before they sample the flag, and they sample a pop's effect on the falling edge right after it. In the random-mask test, the emitted dwords are collected at these same sample points and compared against a queue built from the input masks.

// File: rtl/dwpk_pkg.sv
package dwpk_pkg;
   localparam int unsigned DW_W   = 32;
   localparam int unsigned BEAT_W = 2 * DW_W + 2;

   // vld[1] qualifies hi (earlier dword), vld[0] qualifies lo
   typedef struct packed {
      logic [1:0]      vld;
      logic [DW_W-1:0] hi;
      logic [DW_W-1:0] lo;
   } beat_t;

   localparam logic [1:0] MASK_FULL = 2'b11;
   localparam logic [1:0] MASK_TAIL = 2'b10;
endpackage

// File: rtl/dwpk_merge.sv
module dwpk_merge
   import dwpk_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_wr,
   input  beat_t in_beat,
   input  logic  flush,
   output logic  out_wr,
   output beat_t out_beat
);
   logic            hold_vld_q, hold_vld_d;
   logic [DW_W-1:0] hold_q, hold_d;
   logic            emit;
   beat_t           emit_beat;
   logic [DW_W-1:0] first_dw, second_dw;
   logic            two_dw, one_dw;

   always_comb begin
      first_dw   = in_beat.vld[1] ? in_beat.hi : in_beat.lo;
      second_dw  = in_beat.lo;
      two_dw     = &in_beat.vld;
      one_dw     = ^in_beat.vld;
      emit       = 1'b0;
      emit_beat  = '0;
      hold_vld_d = hold_vld_q;
      hold_d     = hold_q;
      if (in_wr) begin
         if (hold_vld_q) begin
            if (two_dw || one_dw) begin
               emit       = 1'b1;
               emit_beat  = '{vld: MASK_FULL, hi: hold_q, lo: first_dw};
               hold_vld_d = two_dw;
               hold_d     = second_dw;
            end
         end else if (two_dw) begin
            emit      = 1'b1;
            emit_beat = '{vld: MASK_FULL, hi: first_dw, lo: second_dw};
         end else if (one_dw) begin
            hold_vld_d = 1'b1;
            hold_d     = first_dw;
         end
      end else if (flush && hold_vld_q) begin
         emit       = 1'b1;
         emit_beat  = '{vld: MASK_TAIL, hi: hold_q, lo: '0};
         hold_vld_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_vld_q <= 1'b0;
         hold_q     <= '0;
         out_wr     <= 1'b0;
         out_beat   <= '0;
      end else begin
         hold_vld_q <= hold_vld_d;
         hold_q     <= hold_d;
         out_wr     <= emit;
         if (emit) out_beat <= emit_beat;
      end
   end

   // R8: an emitted beat never carries an empty mask
   p_mask_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> (out_beat.vld != 2'b00));

   // R6: a partial beat only follows a flush on a write-free cycle
   p_tail_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wr && out_beat.vld == MASK_TAIL) |-> $past(flush && !in_wr));

   // R5: an empty-mask write produces no beat
   p_zero_mask_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wr && in_beat.vld == 2'b00) |=> !out_wr);

   // R2: a two-dword write always completes a full beat
   p_full_in_full_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wr && in_beat.vld == MASK_FULL) |=> (out_wr && out_beat.vld == MASK_FULL));
endmodule

// File: rtl/dwpk_fill.sv
module dwpk_fill #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned THRESH = 500,
   parameter bit          PF_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic pop,
   output logic prog_full
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] count_q;
   logic             pop_eff;
   logic             above;

   assign pop_eff = pop && (count_q != '0);
   assign above   = (count_q > CNT_W'(THRESH));

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_q + CNT_W'(push) - CNT_W'(pop_eff);
   end

   generate
      if (PF_REG) begin : g_pf_reg
         logic pf_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pf_q <= 1'b0;
            else        pf_q <= above;
         end
         assign prog_full = pf_q;
         // R9: flag rises only two edges after a push
         p_pf_rise_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(prog_full) |-> $past(push, 2));
      end else begin : g_pf_comb
         assign prog_full = above;
         // R9: flag rises only on the edge after a push
         p_pf_rise_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(prog_full) |-> $past(push));
      end
   endgenerate

   // R9: occupancy never exceeds the buffer depth
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/dwpk_pack_stage.sv
module dwpk_pack_stage
   import dwpk_pkg::*;
#(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned THRESH = 500,
   parameter bit          PF_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_wr,
   input  logic [BEAT_W-1:0] in_beat,
   input  logic              flush,
   output logic              out_wr,
   output logic [BEAT_W-1:0] out_beat,
   input  logic              fifo_rd,
   output logic              prog_full
);
   generate
      if (THRESH >= DEPTH) begin : g_bad_thresh
         $error("THRESH must be below DEPTH");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   beat_t in_s, out_s;
   assign in_s     = beat_t'(in_beat);
   assign out_beat = BEAT_W'(out_s);

   dwpk_merge u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_wr    (in_wr),
      .in_beat  (in_s),
      .flush    (flush),
      .out_wr   (out_wr),
      .out_beat (out_s)
   );

   dwpk_fill #(
      .DEPTH  (DEPTH),
      .THRESH (THRESH),
      .PF_REG (PF_REG)
   ) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (out_wr),
      .pop       (fifo_rd),
      .prog_full (prog_full)
   );
endmodule

// File: tb/dwpk_pack_stage_tb_top.sv
module dwpk_pack_stage_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_wr = 1'b0;
   logic [65:0] in_beat = '0;
   logic        flush = 1'b0;
   logic        out_wr;
   logic [65:0] out_beat;
   logic        fifo_rd = 1'b0;
   logic        prog_full;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   bit cap_en  = 1'b0;
   logic [31:0] exp_q[$];
   logic [31:0] got_q[$];

   always #2 clk = ~clk;

   dwpk_pack_stage dut_i (
      .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_beat(in_beat), .flush(flush),
      .out_wr(out_wr), .out_beat(out_beat), .fifo_rd(fifo_rd), .prog_full(prog_full)
   );

   task automatic chk(string tag, logic [66:0] act, logic [66:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive on falling edge, sample on the next falling edge
   task automatic cyc(logic wr, logic [1:0] m, logic [31:0] hi, logic [31:0] lo,
                      logic fl, logic rd);
      in_wr = wr; in_beat = {m, hi, lo}; flush = fl; fifo_rd = rd;
      @(posedge clk);
      @(negedge clk);
      in_wr = 1'b0; flush = 1'b0; fifo_rd = 1'b0;
      if (cap_en && out_wr) begin
         if (out_beat[65]) got_q.push_back(out_beat[63:32]);
         if (out_beat[64]) got_q.push_back(out_beat[31:0]);
         n_tests++;
         if (!(out_beat[65:64] == 2'b11 || out_beat[65:64] == 2'b10)) begin
            n_fail++;
            $display("FAIL R8 actual mask=%b expected=11 or 10", out_beat[65:64]);
         end
      end
   endtask

   task automatic exp_none(string tag);
      chk(tag, {66'd0, out_wr}, 67'd0);
   endtask

   task automatic exp_beat(string tag, logic [1:0] m, logic [31:0] hi, logic [31:0] lo);
      chk(tag, {out_wr, out_beat}, {1'b1, m, hi, lo});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 out_wr", {66'd0, out_wr}, 67'd0);
      chk("R1 prog_full", {66'd0, prog_full}, 67'd0);
      cyc(0, 2'b00, 0, 0, 1, 0);
      exp_none("R1 flush after reset");
   endtask

   task automatic t_full();
      cyc(1, 2'b11, 32'hA0A0_0001, 32'hA0A0_0002, 0, 0);
      exp_beat("R2 full beat", 2'b11, 32'hA0A0_0001, 32'hA0A0_0002);
      cyc(0, 2'b00, 0, 0, 0, 0);
      exp_none("R2 idle after beat");
   endtask

   task automatic t_pair();
      cyc(1, 2'b10, 32'hC0C0_0001, 32'hDEAD_DEAD, 0, 0);
      exp_none("R3 upper-only held");
      cyc(1, 2'b01, 32'hBEEF_BEEF, 32'hC0C0_0002, 0, 0);
      exp_beat("R3 pair", 2'b11, 32'hC0C0_0001, 32'hC0C0_0002);
   endtask

   task automatic t_carry();
      cyc(1, 2'b10, 32'hE000_0001, 0, 0, 0);
      exp_none("R3 held");
      cyc(1, 2'b11, 32'hE000_0002, 32'hE000_0003, 0, 0);
      exp_beat("R4 carry", 2'b11, 32'hE000_0001, 32'hE000_0002);
      cyc(0, 2'b00, 0, 0, 1, 0);
      exp_beat("R6 flush tail", 2'b10, 32'hE000_0003, 32'h0);
      cyc(0, 2'b00, 0, 0, 1, 0);
      exp_none("R7 flush with nothing held");
   endtask

   task automatic t_zero();
      cyc(1, 2'b01, 32'h1111_1111, 32'h5000_0001, 0, 0);
      exp_none("R3 lower-only held");
      cyc(1, 2'b00, 32'h9999_9999, 32'h8888_8888, 0, 0);
      exp_none("R5 empty mask");
      cyc(1, 2'b01, 32'h7777_7777, 32'h5000_0002, 0, 0);
      exp_beat("R5 hold kept", 2'b11, 32'h5000_0001, 32'h5000_0002);
   endtask

   task automatic t_flush_on_write();
      cyc(1, 2'b10, 32'h6000_0001, 0, 1, 0);
      exp_none("R7 flush with write");
      cyc(0, 2'b00, 0, 0, 0, 0);
      exp_none("R7 idle");
      cyc(1, 2'b10, 32'h6000_0002, 0, 0, 0);
      exp_beat("R7 hold survived flush", 2'b11, 32'h6000_0001, 32'h6000_0002);
   endtask

   task automatic t_example();
      cyc(1, 2'b11, 32'd0, 32'd1, 0, 0);
      exp_beat("R10 ex beat0", 2'b11, 32'd0, 32'd1);
      cyc(1, 2'b10, 32'd2, 32'hF, 0, 0);
      exp_none("R10 ex gap");
      cyc(1, 2'b01, 32'hF, 32'd3, 0, 0);
      exp_beat("R10 ex beat1", 2'b11, 32'd2, 32'd3);
      cyc(1, 2'b10, 32'd4, 32'hF, 0, 0);
      exp_none("R10 ex gap2");
      cyc(0, 2'b00, 0, 0, 1, 0);
      exp_beat("R10 ex tail", 2'b10, 32'd4, 32'd0);
   endtask

   task automatic t_random();
      logic [31:0] seq = 32'h1000_0000;
      exp_q.delete(); got_q.delete();
      cap_en = 1'b1;
      for (int i = 0; i < 400; i++) begin
         logic [1:0] m = 2'($urandom_range(0, 3));
         logic [31:0] hi = $urandom, lo = $urandom;
         if ($urandom_range(0, 9) == 0) begin
            cyc(0, 2'b00, 0, 0, 1, 1);
         end else begin
            if (m[1]) begin hi = seq; seq++; exp_q.push_back(hi); end
            if (m[0]) begin lo = seq; seq++; exp_q.push_back(lo); end
            cyc(1, m, hi, lo, 0, 1);
         end
      end
      cyc(0, 2'b00, 0, 0, 1, 1);
      cyc(0, 2'b00, 0, 0, 0, 1);
      cap_en = 1'b0;
      chk("R10 dword count", 67'(got_q.size()), 67'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk("R10 dword order", 67'(got_q[i]), 67'(exp_q[i]));
   endtask

   task automatic t_fill();
      do_reset();
      for (int i = 0; i < 3; i++) cyc(0, 2'b00, 0, 0, 0, 1);
      for (int i = 0; i < 500; i++) cyc(1, 2'b11, i, i, 0, 0);
      cyc(0, 2'b00, 0, 0, 0, 0);
      chk("R9 500 held not full", {66'd0, prog_full}, 67'd0);
      cyc(1, 2'b11, 1, 1, 0, 0);
      chk("R9 flag lags push", {66'd0, prog_full}, 67'd0);
      cyc(0, 2'b00, 0, 0, 0, 0);
      chk("R9 501 held full", {66'd0, prog_full}, 67'd1);
      cyc(0, 2'b00, 0, 0, 0, 1);
      chk("R9 pop clears", {66'd0, prog_full}, 67'd0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_full();
      t_pair();
      t_carry();
      t_zero();
      t_flush_on_write();
      t_example();
      t_random();
      t_fill();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule